// File: doc/BRIEF.md
# Tick Counter with Compare Interrupt

This block keeps a 63-bit counter that advances by one on every clock where a count-enable input is high, next to a 63-bit compare value. Software sets the counter and the compare value through a single write port; the current count, with a sticky flag in its top bit, is always visible on a read bus. When the counter steps onto the compare value, the block raises a one-cycle request on one of two soft-interrupt lines.

A build parameter picks which soft-interrupt line an instance drives. The processor-tick instance uses the timer-match line, and the system-tick and hypervisor-tick instances use the system-timer-match line. The top bit of a count write is kept as a sticky non-privileged-trap flag. The top bit of a compare write turns the interrupt off. A compare value of zero never matches. A compare value that the counter has already reached is not lost: the request is raised on the next step of the counter.

Top module: `tick_compare_timer`

## Requirements
- R1: A write with `wr_sel`=0 loads `wr_data[62:0]` into the counter and `wr_data[63]` into the trap flag. In that cycle the write takes the place of a step.
- R2: `rd_count` shows the counter in bits 62:0, and the trap flag in bit 63.
- R3: On each clock where `tick_en` is high and no count write occurs, the counter grows by one. Otherwise it holds.
- R4: A write with `wr_sel`=1 loads `wr_data[62:0]` as the compare value and `wr_data[63]` as the interrupt-disable flag (1 = disabled).
- R5: A compare value of zero never raises a request.
- R6: While the disable flag is 1, no request is raised.
- R7: When a step moves the counter onto the compare value, a request is raised for exactly one cycle. It appears in the cycle after that clock edge, and that is also the cycle in which `rd_count` first shows the compare value.
- R8: A request drives `sint_set` to 2'b01 when `SYS_KIND`=0 and to 2'b10 when `SYS_KIND`=1. With no request, `sint_set` is 2'b00.
- R9: The counter wraps from 2^63-1 to 0.
- R10: A nonzero, enabled compare write whose value is less than or equal to the current count arms a late match. That match raises one request on the next step, and after that no further request comes from it.
- R11: Reset sets the counter to 0, the trap flag to 1, the compare value to 0 and the disable flag to 1. It also clears any armed late match and any request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable, one step per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 = count, 1 = compare |
| wr_data | input | 64 | Write data, bit 63 is the flag bit |
| rd_count | output | 64 | Current count with the trap flag in bit 63 |
| sint_set | output | 2 | Soft-interrupt set request: bit 0 timer match, bit 1 system-timer match |

## Verification
Every register write and every counter step shows on `rd_count` one clock after the edge that takes it. A request is produced by the same edge that performs the matching step, so it appears together with the first count value at or past the match. The bench drives its inputs on falling edges and samples at the next falling edge, which is half a cycle after the edge that updates the register. For each step it checks the count and the request as a pair, and it counts the pulses over a whole window. This separates a request that is early, late or repeated from one that is correct.

// File: rtl/tick_cmp_pkg.sv
package tick_cmp_pkg;
  typedef enum logic {
    SEL_COUNT = 1'b0,
    SEL_LIMIT = 1'b1
  } reg_sel_e;

  localparam logic [1:0] SINT_TIMER  = 2'b01;
  localparam logic [1:0] SINT_SYSTEM = 2'b10;
endpackage

// File: rtl/tcc_counter.sv
module tcc_counter #(
  parameter int CNT_W = 63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             ld,
  input  logic [CNT_W:0]   ld_data,
  output logic [CNT_W-1:0] cnt_q,
  output logic             npt_q,
  output logic             step
);
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c);
    return c + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  assign step = tick_en && !ld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      npt_q <= 1'b1;
    end else if (ld) begin
      cnt_q <= ld_data[CNT_W-1:0];
      npt_q <= ld_data[CNT_W];
    end else if (step) begin
      cnt_q <= next_count(cnt_q);
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cnt_q == next_count($past(cnt_q))); // R3
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !ld) |=> $stable(cnt_q) && $stable(npt_q)); // R3
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt_q == $past(ld_data[CNT_W-1:0])) && (npt_q == $past(ld_data[CNT_W]))); // R1
endmodule

// File: rtl/tcc_compare.sv
module tcc_compare #(
  parameter int CNT_W = 63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             lim_wr,
  input  logic [CNT_W:0]   wr_data,
  input  logic [CNT_W-1:0] cnt_q,
  output logic             hit_q
);
  logic [CNT_W-1:0] lim_q;
  logic             dis_q;
  logic             late_q;
  logic             armed;
  logic             cross_evt;
  logic             fire_evt;
  logic             late_evt;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c);
    return c + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic already_passed(input logic [CNT_W-1:0] lim,
                                          input logic [CNT_W-1:0] c);
    return (lim != '0) && (lim <= c);
  endfunction

  assign armed     = !dis_q && (lim_q != '0);
  assign cross_evt = armed && (next_count(cnt_q) == lim_q);
  assign fire_evt  = step && !lim_wr && armed && (cross_evt || late_q);
  assign late_evt  = lim_wr && !wr_data[CNT_W] &&
                     already_passed(wr_data[CNT_W-1:0], cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_q  <= '0;
      dis_q  <= 1'b1;
      late_q <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      hit_q <= fire_evt;
      if (lim_wr) begin
        lim_q  <= wr_data[CNT_W-1:0];
        dis_q  <= wr_data[CNT_W];
        late_q <= late_evt;
      end else if (fire_evt) begin
        late_q <= 1'b0;
      end
    end
  end

  AST_HIT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> !$past(dis_q) && $past(step)); // R6
  AST_HIT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> $past(lim_q) != '0); // R5
  AST_HIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |=> !hit_q); // R7
  AST_LATE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> !late_q); // R10
  AST_LIM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    lim_wr |=> (lim_q == $past(wr_data[CNT_W-1:0])) && (dis_q == $past(wr_data[CNT_W]))); // R4
endmodule

// File: rtl/tick_compare_timer.sv
module tick_compare_timer
  import tick_cmp_pkg::*;
#(
  parameter int CNT_W    = 63,
  parameter bit SYS_KIND = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_en,
  input  logic           wr_en,
  input  logic           wr_sel,
  input  logic [CNT_W:0] wr_data,
  output logic [CNT_W:0] rd_count,
  output logic [1:0]     sint_set
);
  logic             cnt_ld;
  logic             lim_ld;
  logic             step;
  logic             npt_q;
  logic             hit;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       sint_code;

  assign cnt_ld = wr_en && (reg_sel_e'(wr_sel) == SEL_COUNT);
  assign lim_ld = wr_en && (reg_sel_e'(wr_sel) == SEL_LIMIT);

  tcc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .ld      (cnt_ld),
    .ld_data (wr_data),
    .cnt_q   (cnt_q),
    .npt_q   (npt_q),
    .step    (step)
  );

  tcc_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .lim_wr  (lim_ld),
    .wr_data (wr_data),
    .cnt_q   (cnt_q),
    .hit_q   (hit)
  );

  generate
    if (SYS_KIND) begin : g_sys
      assign sint_code = SINT_SYSTEM;
    end else begin : g_cpu
      assign sint_code = SINT_TIMER;
    end
  endgenerate

  assign rd_count = {npt_q, cnt_q};
  assign sint_set = hit ? sint_code : 2'b00;

  AST_SINT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sint_set)); // R8
  AST_READ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ld |=> rd_count[CNT_W] == $past(wr_data[CNT_W])); // R2
endmodule

// File: tb/tick_compare_timer_test.sv
module tick_compare_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_count;
  logic [63:0] rd_count_sys;
  logic [1:0]  sint_set;
  logic [1:0]  sint_sys;
  int total = 0;
  int bad = 0;

  localparam logic [63:0] TOPB = 64'h8000_0000_0000_0000;

  always #2 clk = ~clk;

  tick_compare_timer #(.CNT_W(63), .SYS_KIND(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_count(rd_count), .sint_set(sint_set));

  tick_compare_timer #(.CNT_W(63), .SYS_KIND(1'b1)) uut_sys (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_count(rd_count_sys), .sint_set(sint_sys));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk("R11 count after reset", rd_count, TOPB);
    chk("R11 no request after reset", {62'd0, sint_set}, 64'd0);
  endtask

  task automatic test_count_write();
    wr(1'b0, 64'h0000_0000_0000_0010);
    chk("R1 R2 count load flag clear", rd_count, 64'h10);
    wr(1'b0, TOPB | 64'h1234);
    chk("R1 R2 count load flag set", rd_count, TOPB | 64'h1234);
  endtask

  task automatic test_stepping();
    wr(1'b0, 64'd50);
    tick_en = 1'b1;
    repeat (5) @(negedge clk);
    tick_en = 1'b0;
    chk("R3 five steps", rd_count, 64'd55);
    repeat (3) @(negedge clk);
    chk("R3 hold without enable", rd_count, 64'd55);
  endtask

  task automatic test_crossing();
    int pulses = 0;
    wr(1'b0, 64'd100);
    wr(1'b1, 64'd105);
    tick_en = 1'b1;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      chk("R3 step value", rd_count, 64'd100 + 64'(i));
      chk("R7 R8 request at compare", {62'd0, sint_set},
          (rd_count == 64'd105) ? 64'd1 : 64'd0);
      chk("R8 system line", {62'd0, sint_sys},
          (rd_count_sys == 64'd105) ? 64'd2 : 64'd0);
      if (sint_set != 2'b00) pulses++;
    end
    tick_en = 1'b0;
    chk("R4 R7 one pulse", 64'(pulses), 64'd1);
  endtask

  task automatic test_zero_and_wrap();
    int pulses = 0;
    wr(1'b1, 64'd0);
    wr(1'b0, 64'h7FFF_FFFF_FFFF_FFFE);
    tick_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (sint_set != 2'b00) pulses++;
    end
    tick_en = 1'b0;
    chk("R9 wrap to low values", rd_count, 64'd2);
    chk("R5 zero compare silent", 64'(pulses), 64'd0);
  endtask

  task automatic test_disabled();
    int pulses = 0;
    wr(1'b0, 64'd100);
    wr(1'b1, TOPB | 64'd105);
    tick_en = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (sint_set != 2'b00 || sint_sys != 2'b00) pulses++;
    end
    tick_en = 1'b0;
    chk("R6 disabled silent", 64'(pulses), 64'd0);
    chk("R4 count unaffected", rd_count, 64'd110);
  endtask

  task automatic test_late();
    int pulses = 0;
    wr(1'b0, 64'd200);
    wr(1'b1, 64'd150);
    repeat (3) begin
      @(negedge clk);
      if (sint_set != 2'b00) pulses++;
    end
    chk("R10 waits for a step", 64'(pulses), 64'd0);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    chk("R10 late count", rd_count, 64'd201);
    chk("R10 late request", {62'd0, sint_set}, 64'd1);
    tick_en = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (sint_set != 2'b00) pulses++;
    end
    tick_en = 1'b0;
    chk("R10 only once", 64'(pulses), 64'd0);
  endtask

  task automatic test_reset_clears();
    int pulses = 0;
    wr(1'b0, 64'd300);
    wr(1'b1, 64'd250);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk("R11 reset state", rd_count, TOPB);
    tick_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (sint_set != 2'b00) pulses++;
    end
    tick_en = 1'b0;
    chk("R11 pending cleared", 64'(pulses), 64'd0);
    chk("R11 R2 flag kept while stepping", rd_count, TOPB | 64'd3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_count_write();
    test_stepping();
    test_crossing();
    test_zero_and_wrap();
    test_disabled();
    test_late();
    test_reset_clears();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 20000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule